// File: doc/BRIEF.md
# MMU control and status register file

This block is the software-visible control face of a two-level paged MMU. It keeps the segment-table frame numbers for the supervisor and user address spaces. It also holds a TLB control location and a 16-bit command/status word. These four registers sit at consecutive 32-bit offsets, and each one can be reached either as a whole longword or as one of its two 16-bit halves. The block drives the enables for supervisor and user translation, the external cache, the instruction cache and the floating-point coprocessor. It emits single-cycle invalidation pulses toward the TLB and the external cache, and it records translation faults reported by the table-walk logic.

The fault flags are sticky. Hardware sets them, and only software can clear them; software cannot set them. Some accesses have side effects beyond storing a value. Any write to a segment pointer, even one that stores the same value, flushes that space from both the TLB and the external cache. Turning the external cache enable back on flushes the whole cache. Writing the TLB control location flushes one space, and a longword read of it flushes the whole TLB.

Top module: `mmu_ctl_regs`

## Requirements
- R1: After reset, all registers read as zero, all enables are low and no flush pulse is active.
- R2: `addr_i[3:2]` selects the register: 0 is the supervisor pointer, 1 is the user pointer, 2 is TLB control and 3 is command/status. A read returns `rvalid_o` high together with `rdata_o` exactly one cycle after the request.
- R3: When `long_i`=0 the access is a shortword. `addr_i[1]`=1 selects bits 15:0 and `addr_i[1]`=0 selects bits 31:16. Shortword data travels in `wdata_i[15:0]`/`rdata_o[15:0]`, and `rdata_o[31:16]` reads zero. A longword access ignores `addr_i[1:0]`.
- R4: Each segment pointer keeps FRAME_W frame bits at bits FRAME_W-1:0, and bits above them read zero. Any write to a pointer, of either width and including a write of the unchanged value, raises that space's `xcache_flush_*_o` and `tlb_flush_*_o` for exactly one cycle, one cycle after the write.
- R5: TLB control always reads zero. A longword read of it pulses `tlb_flush_all_o`. A write pulses `tlb_flush_sup_o` if bit 15 of the written value (placed in its lanes) is 1, and `tlb_flush_usr_o` otherwise. A TLB control write causes no cache flush.
- R6: Status bits 15, 14, 13 and 3 are sticky. A status write leaves each of them set only where the written bit is 1, so writing 0 clears a bit and writing 1 keeps it. Software can never set them.
- R7: A cycle with `fault_i`=1 sets status bit 3, and also bit 15 if `fault_kind_i[2]` is set (page table fault), bit 14 if `fault_kind_i[1]` is set (page fault) and bit 13 if `fault_kind_i[0]` is set (protection fault). Bits set in this way are applied after a software write in the same cycle.
- R8: Status control bits are writable and drive outputs: bit 6 drives `fpu_en_o`, bit 5 `icache_en_o`, bit 2 `xcache_en_o`, bit 1 `sup_map_en_o` and bit 0 `usr_map_en_o`. A write that turns bit 2 from 0 to 1 pulses `xcache_flush_all_o` for one cycle.
- R9: Status bits 12:7 and 4, and bits 31:16 of the status longword, read zero and ignore writes. A shortword write to the high half of the status register changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| long_i | input | 1 | 1 = longword access, 0 = shortword |
| addr_i | input | 4 | Byte offset of the access |
| wdata_i | input | 32 | Write data (shortword in bits 15:0) |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| fault_i | input | 1 | Translation fault report |
| fault_kind_i | input | 3 | {page table, page, protection} fault kinds |
| sup_frame_o | output | FRAME_W | Supervisor segment-table frame number |
| usr_frame_o | output | FRAME_W | User segment-table frame number |
| usr_map_en_o | output | 1 | User translation enable |
| sup_map_en_o | output | 1 | Supervisor translation enable |
| xcache_en_o | output | 1 | External cache enable |
| icache_en_o | output | 1 | Instruction cache enable |
| fpu_en_o | output | 1 | Coprocessor enable |
| tlb_flush_all_o | output | 1 | Invalidate all TLB entries |
| tlb_flush_sup_o | output | 1 | Invalidate supervisor TLB entries |
| tlb_flush_usr_o | output | 1 | Invalidate user TLB entries |
| xcache_flush_all_o | output | 1 | Invalidate the whole external cache |
| xcache_flush_sup_o | output | 1 | Invalidate supervisor cache lines |
| xcache_flush_usr_o | output | 1 | Invalidate user cache lines |

## Verification
The bench rewrites a pointer with its unchanged value. A design that flushes only on a change would show no pulse there. It writes shortwords to both halves of a pointer and reads them back, which exposes any swap of the half mapping or frame bits that are not masked. It writes ones to the sticky flags after clearing them, and it raises a fault in the same cycle as a status write. A design that lets software set flags, or that applies the write after the fault, would show the wrong status word. It also writes the cache enable with an unchanged 1 and with a 1-to-0 change, and a design that pulses on any write of bit 2 would flush there.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned HW = 16;
  localparam int unsigned NREG = 4;

  typedef enum logic [1:0] {
    RI_SUP = 2'd0,
    RI_USR = 2'd1,
    RI_TLB = 2'd2,
    RI_CSR = 2'd3
  } reg_idx_e;

  // status bit positions
  localparam int unsigned B_PTF  = 15;
  localparam int unsigned B_PGF  = 14;
  localparam int unsigned B_PRF  = 13;
  localparam int unsigned B_FPU  = 6;
  localparam int unsigned B_ICE  = 5;
  localparam int unsigned B_BERR = 3;
  localparam int unsigned B_XCE  = 2;
  localparam int unsigned B_SME  = 1;
  localparam int unsigned B_UME  = 0;
  localparam int unsigned B_TLB_SUP = 15;

  localparam logic [HW-1:0] CTL_MASK = HW'((1 << B_FPU) | (1 << B_ICE) | (1 << B_XCE) |
                                          (1 << B_SME) | (1 << B_UME));
  localparam logic [HW-1:0] STK_MASK = HW'((1 << B_PTF) | (1 << B_PGF) | (1 << B_PRF) |
                                          (1 << B_BERR));

  typedef struct packed {
    logic ptab;
    logic page;
    logic prot;
  } fault_kind_t;
endpackage

// File: rtl/mmu_bus_decode.sv
module mmu_bus_decode
  import mmu_ctl_pkg::*;
(
  input  logic                req_i,
  input  logic                we_i,
  input  logic                long_i,
  input  logic [3:0]          addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [NREG-1:0]     wr_sel_o,
  output logic [NREG-1:0]     rd_sel_o,
  output logic [DW-1:0]       wmask_o,
  output logic [DW-1:0]       wval_o,
  output logic                rd_long_o,
  output logic                rd_lo_o
);
  logic [1:0] idx;
  assign idx = addr_i[3:2];

  for (genvar r = 0; r < NREG; r++) begin : g_sel
    assign wr_sel_o[r] = req_i &&  we_i && (idx == 2'(r));
    assign rd_sel_o[r] = req_i && !we_i && (idx == 2'(r));
  end

  always_comb begin
    if (long_i) begin
      wmask_o = '1;
      wval_o  = wdata_i;
    end else begin
      wmask_o = addr_i[1] ? {{HW{1'b0}}, {HW{1'b1}}} : {{HW{1'b1}}, {HW{1'b0}}};
      wval_o  = {wdata_i[HW-1:0], wdata_i[HW-1:0]};
    end
  end

  assign rd_long_o = long_i;
  assign rd_lo_o   = addr_i[1];
endmodule

// File: rtl/mmu_stp_reg.sv
module mmu_stp_reg
  import mmu_ctl_pkg::*;
#(
  parameter int unsigned FRAME_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [DW-1:0]      wmask_i,
  input  logic [DW-1:0]      wval_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] frame_d;

  always_comb begin
    frame_d = frame_q;
    if (wr_i) begin
      frame_d = (frame_q & ~wmask_i[FRAME_W-1:0]) | (wval_i[FRAME_W-1:0] & wmask_i[FRAME_W-1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frame_q <= '0;
    else         frame_q <= frame_d;
  end

  assign frame_o = frame_q;
endmodule

// File: rtl/mmu_csr_reg.sv
module mmu_csr_reg
  import mmu_ctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wmask_i,
  input  logic [DW-1:0] wval_i,
  input  logic          fault_i,
  input  fault_kind_t   fault_kind_i,
  output logic [HW-1:0] csr_o,
  output logic          xflush_all_o
);
  logic [HW-1:0] ctl_q, ctl_d;
  logic [HW-1:0] stk_q, stk_d;
  logic [HW-1:0] flt_set;
  logic          lo_wr;
  logic          xflush_q;

  // only the low half carries status bits
  assign lo_wr = wr_i && (wmask_i[HW-1:0] == {HW{1'b1}});

  always_comb begin
    flt_set = '0;
    if (fault_i) begin
      flt_set[B_BERR] = 1'b1;
      flt_set[B_PTF]  = fault_kind_i.ptab;
      flt_set[B_PGF]  = fault_kind_i.page;
      flt_set[B_PRF]  = fault_kind_i.prot;
    end
  end

  always_comb begin
    ctl_d = ctl_q;
    stk_d = stk_q;
    if (lo_wr) begin
      ctl_d = wval_i[HW-1:0] & CTL_MASK;
      stk_d = stk_q & wval_i[HW-1:0];
    end
    stk_d = (stk_d | flt_set) & STK_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q    <= '0;
      stk_q    <= '0;
      xflush_q <= 1'b0;
    end else begin
      ctl_q    <= ctl_d;
      stk_q    <= stk_d;
      xflush_q <= lo_wr && ctl_d[B_XCE] && !ctl_q[B_XCE];
    end
  end

  assign csr_o        = ctl_q | stk_q;
  assign xflush_all_o = xflush_q;
endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
  import mmu_ctl_pkg::*;
#(
  parameter int unsigned FRAME_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic               long_i,
  input  logic [3:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic               rvalid_o,
  output logic [31:0]        rdata_o,
  input  logic               fault_i,
  input  logic [2:0]         fault_kind_i,
  output logic [FRAME_W-1:0] sup_frame_o,
  output logic [FRAME_W-1:0] usr_frame_o,
  output logic               usr_map_en_o,
  output logic               sup_map_en_o,
  output logic               xcache_en_o,
  output logic               icache_en_o,
  output logic               fpu_en_o,
  output logic               tlb_flush_all_o,
  output logic               tlb_flush_sup_o,
  output logic               tlb_flush_usr_o,
  output logic               xcache_flush_all_o,
  output logic               xcache_flush_sup_o,
  output logic               xcache_flush_usr_o
);
  localparam int unsigned NSTP  = 2;
  localparam int unsigned PAD_W = DW - FRAME_W;

  logic [NREG-1:0]    wr_sel, rd_sel;
  logic [DW-1:0]      wmask, wval;
  logic               rd_long, rd_lo;
  logic [FRAME_W-1:0] frame [NSTP];
  logic [HW-1:0]      csr_q;
  logic               csr_wr;
  logic [DW-1:0]      tlb_wv;
  logic [DW-1:0]      rd_full;
  logic [DW-1:0]      rd_word;

  logic rvalid_q;
  logic [DW-1:0] rdata_q;
  logic tlb_all_q, tlb_sup_q, tlb_usr_q, xc_sup_q, xc_usr_q;

  mmu_bus_decode u_dec (
    .req_i     (req_i),
    .we_i      (we_i),
    .long_i    (long_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .wr_sel_o  (wr_sel),
    .rd_sel_o  (rd_sel),
    .wmask_o   (wmask),
    .wval_o    (wval),
    .rd_long_o (rd_long),
    .rd_lo_o   (rd_lo)
  );

  for (genvar s = 0; s < NSTP; s++) begin : g_stp
    mmu_stp_reg #(.FRAME_W(FRAME_W)) u_stp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_sel[s]),
      .wmask_i (wmask),
      .wval_i  (wval),
      .frame_o (frame[s])
    );
  end

  assign csr_wr = wr_sel[RI_CSR];

  mmu_csr_reg u_csr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (csr_wr),
    .wmask_i      (wmask),
    .wval_i       (wval),
    .fault_i      (fault_i),
    .fault_kind_i (fault_kind_t'(fault_kind_i)),
    .csr_o        (csr_q),
    .xflush_all_o (xcache_flush_all_o)
  );

  assign tlb_wv = wval & wmask;

  always_comb begin
    unique case (addr_i[3:2])
      RI_SUP:  rd_full = {{PAD_W{1'b0}}, frame[RI_SUP]};
      RI_USR:  rd_full = {{PAD_W{1'b0}}, frame[RI_USR]};
      RI_TLB:  rd_full = '0;
      default: rd_full = {{HW{1'b0}}, csr_q};
    endcase
    if (rd_long)    rd_word = rd_full;
    else if (rd_lo) rd_word = {{HW{1'b0}}, rd_full[HW-1:0]};
    else            rd_word = {{HW{1'b0}}, rd_full[DW-1:HW]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q  <= 1'b0;
      rdata_q   <= '0;
      tlb_all_q <= 1'b0;
      tlb_sup_q <= 1'b0;
      tlb_usr_q <= 1'b0;
      xc_sup_q  <= 1'b0;
      xc_usr_q  <= 1'b0;
    end else begin
      rvalid_q  <= |rd_sel;
      rdata_q   <= (|rd_sel) ? rd_word : '0;
      tlb_all_q <= rd_sel[RI_TLB] && rd_long;
      tlb_sup_q <= wr_sel[RI_SUP] || (wr_sel[RI_TLB] &&  tlb_wv[B_TLB_SUP]);
      tlb_usr_q <= wr_sel[RI_USR] || (wr_sel[RI_TLB] && !tlb_wv[B_TLB_SUP]);
      xc_sup_q  <= wr_sel[RI_SUP];
      xc_usr_q  <= wr_sel[RI_USR];
    end
  end

  assign rvalid_o           = rvalid_q;
  assign rdata_o            = rdata_q;
  assign tlb_flush_all_o    = tlb_all_q;
  assign tlb_flush_sup_o    = tlb_sup_q;
  assign tlb_flush_usr_o    = tlb_usr_q;
  assign xcache_flush_sup_o = xc_sup_q;
  assign xcache_flush_usr_o = xc_usr_q;
  assign sup_frame_o        = frame[RI_SUP];
  assign usr_frame_o        = frame[RI_USR];
  assign fpu_en_o           = csr_q[B_FPU];
  assign icache_en_o        = csr_q[B_ICE];
  assign xcache_en_o        = csr_q[B_XCE];
  assign sup_map_en_o       = csr_q[B_SME];
  assign usr_map_en_o       = csr_q[B_UME];
endmodule

// File: rtl/mmu_ctl_regs_chk.sv
module mmu_ctl_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic        long_i,
  input logic [3:0]  addr_i,
  input logic        fault_i,
  input logic        rvalid_o,
  input logic [15:0] csr_q,
  input logic        csr_wr,
  input logic        xcache_en_o,
  input logic        tlb_flush_all_o,
  input logic        tlb_flush_sup_o,
  input logic        tlb_flush_usr_o,
  input logic        xcache_flush_all_o,
  input logic        xcache_flush_sup_o,
  input logic        xcache_flush_usr_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_rd_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (rvalid_o == $past(req_i && !we_i)));

  assert_ptr_flush_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xcache_flush_usr_o |-> tlb_flush_usr_o) and (xcache_flush_sup_o |-> tlb_flush_sup_o));

  assert_tlb_all_on_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && tlb_flush_all_o |-> rvalid_o && $past(long_i && addr_i[3:2] == 2'd2));

  assert_sticky_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(csr_q[3]) && !$past(csr_wr) |-> csr_q[3]);

  assert_fault_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> csr_q[3]);

  assert_xflush_on_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && xcache_flush_all_o |-> xcache_en_o && !$past(xcache_en_o));

  assert_reserved_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_q & 16'h1F90) == 16'h0);
endmodule

bind mmu_ctl_regs mmu_ctl_regs_chk u_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .req_i              (req_i),
  .we_i               (we_i),
  .long_i             (long_i),
  .addr_i             (addr_i),
  .fault_i            (fault_i),
  .rvalid_o           (rvalid_o),
  .csr_q              (csr_q),
  .csr_wr             (csr_wr),
  .xcache_en_o        (xcache_en_o),
  .tlb_flush_all_o    (tlb_flush_all_o),
  .tlb_flush_sup_o    (tlb_flush_sup_o),
  .tlb_flush_usr_o    (tlb_flush_usr_o),
  .xcache_flush_all_o (xcache_flush_all_o),
  .xcache_flush_sup_o (xcache_flush_sup_o),
  .xcache_flush_usr_o (xcache_flush_usr_o)
);

// File: tb/mmu_ctl_regs_tb_top.sv
module mmu_ctl_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 20;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0, long_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic fault_i = 1'b0;
  logic [2:0] fault_kind_i = '0;
  logic rvalid_o;
  logic [31:0] rdata_o;
  logic [FW-1:0] sup_frame_o, usr_frame_o;
  logic usr_map_en_o, sup_map_en_o, xcache_en_o, icache_en_o, fpu_en_o;
  logic tlb_flush_all_o, tlb_flush_sup_o, tlb_flush_usr_o;
  logic xcache_flush_all_o, xcache_flush_sup_o, xcache_flush_usr_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [5:0]  pulses;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mmu_ctl_regs #(.FRAME_W(FW)) dut_i (.*);

  // monitor: pop expected read data as results appear
  always @(negedge clk_i) begin
    if (rvalid_o) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected read data act=%h exp=none", rdata_o);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata_o !== e) begin
          n_fail++;
          $display("FAIL %s read act=%h exp=%h", t, rdata_o, e);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one bus cycle; pulses captured in the cycle after
  task automatic acc(input logic w, input logic lw, input logic [3:0] a, input logic [31:0] d,
                     input logic f, input logic [2:0] k);
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; long_i = lw; addr_i = a; wdata_i = d;
    fault_i = f; fault_kind_i = k;
    @(negedge clk_i);
    req_i = 1'b0; fault_i = 1'b0; fault_kind_i = '0;
    // {tlb_all, tlb_sup, tlb_usr, xc_all, xc_sup, xc_usr}
    pulses = {tlb_flush_all_o, tlb_flush_sup_o, tlb_flush_usr_o,
              xcache_flush_all_o, xcache_flush_sup_o, xcache_flush_usr_o};
  endtask

  task automatic wr(input logic lw, input logic [3:0] a, input logic [31:0] d);
    acc(1'b1, lw, a, d, 1'b0, 3'b000);
  endtask

  task automatic rd(input logic lw, input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    acc(1'b0, lw, a, 32'h0, 1'b0, 3'b000);
  endtask

  task automatic flt(input logic [2:0] k);
    @(negedge clk_i);
    fault_i = 1'b1; fault_kind_i = k;
    @(negedge clk_i);
    fault_i = 1'b0; fault_kind_i = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 enables", {27'b0, fpu_en_o, icache_en_o, xcache_en_o, sup_map_en_o, usr_map_en_o}, 32'h0);
    chk("R1 frames", {sup_frame_o, usr_frame_o}, 40'h0);
    chk("R1 pulses", {26'b0, tlb_flush_all_o, tlb_flush_sup_o, tlb_flush_usr_o,
                      xcache_flush_all_o, xcache_flush_sup_o, xcache_flush_usr_o}, 32'h0);
    rd(1'b1, 4'h0, 32'h0, "R1 sup");
    rd(1'b1, 4'h4, 32'h0, "R1 usr");
    rd(1'b1, 4'hC, 32'h0, "R1 csr");

    // R2/R4 supervisor pointer
    wr(1'b1, 4'h0, 32'h0001_2345);
    chk("R4 sup write pulses", 32'(pulses), 32'b010_010);
    chk("R2 sup frame out", 32'(sup_frame_o), 32'h12345);
    rd(1'b1, 4'h0, 32'h0001_2345, "R2 sup readback");
    // R4 reserved upper bits
    wr(1'b1, 4'h4, 32'hFFFF_FFFF);
    chk("R4 usr write pulses", 32'(pulses), 32'b001_001);
    rd(1'b1, 4'h4, 32'h000F_FFFF, "R4 usr upper bits zero");
    // R3 shortword halves
    wr(1'b0, 4'h6, 32'h0000_ABCD);
    rd(1'b1, 4'h4, 32'h000F_ABCD, "R3 low half write");
    wr(1'b0, 4'h4, 32'h0000_1234);
    chk("R4 short write pulses", 32'(pulses), 32'b001_001);
    rd(1'b1, 4'h4, 32'h0004_ABCD, "R3 high half write");
    rd(1'b0, 4'h4, 32'h0000_0004, "R3 high half read");
    rd(1'b0, 4'h6, 32'h0000_ABCD, "R3 low half read");
    // R4 same-value rewrite
    wr(1'b1, 4'h4, 32'h0004_ABCD);
    chk("R4 unchanged rewrite pulses", 32'(pulses), 32'b001_001);

    // R5 TLB control
    wr(1'b1, 4'h8, 32'h0000_0000);
    chk("R5 tlb write user", 32'(pulses), 32'b001_000);
    wr(1'b1, 4'h8, 32'h0000_8000);
    chk("R5 tlb write sup", 32'(pulses), 32'b010_000);
    wr(1'b0, 4'hA, 32'h0000_8000);
    chk("R5 tlb short low sup", 32'(pulses), 32'b010_000);
    wr(1'b0, 4'h8, 32'h0000_8000);
    chk("R5 tlb short high user", 32'(pulses), 32'b001_000);
    rd(1'b1, 4'h8, 32'h0, "R5 tlb long read");
    chk("R5 long read flush all", 32'(pulses), 32'b100_000);
    rd(1'b0, 4'hA, 32'h0, "R5 tlb short read");
    chk("R5 short read no flush", 32'(pulses), 32'b000_000);

    // R8 / R9 control bits
    wr(1'b1, 4'hC, 32'hFFFF_FFFF);
    chk("R8 cache on flush", 32'(pulses), 32'b000_100);
    chk("R8 enables", {27'b0, fpu_en_o, icache_en_o, xcache_en_o, sup_map_en_o, usr_map_en_o}, 32'h1F);
    rd(1'b1, 4'hC, 32'h0000_0067, "R9 reserved zero");
    wr(1'b1, 4'hC, 32'h0000_0067);
    chk("R8 no flush when already on", 32'(pulses), 32'b000_000);
    wr(1'b1, 4'hC, 32'h0000_0063);
    chk("R8 no flush on turn off", 32'(pulses), 32'b000_000);
    chk("R8 cache off", 32'(xcache_en_o), 32'h0);
    wr(1'b1, 4'hC, 32'h0000_0067);
    chk("R8 toggle flush", 32'(pulses), 32'b000_100);

    // R7 faults
    flt(3'b100);
    rd(1'b1, 4'hC, 32'h0000_806F, "R7 page table fault");
    flt(3'b010);
    rd(1'b1, 4'hC, 32'h0000_C06F, "R7 page fault accumulates");
    // R9 high half write ignored
    wr(1'b0, 4'hC, 32'h0000_0000);
    rd(1'b0, 4'hE, 32'h0000_C06F, "R9 high half write ignored");
    rd(1'b0, 4'hC, 32'h0000_0000, "R9 high half reads zero");
    // R6 sticky clear rules
    wr(1'b1, 4'hC, 32'h0000_FFFF);
    rd(1'b1, 4'hC, 32'h0000_C06F, "R6 write ones keeps");
    wr(1'b1, 4'hC, 32'h0000_4067);
    rd(1'b1, 4'hC, 32'h0000_4067, "R6 partial clear");
    wr(1'b1, 4'hC, 32'h0000_0067);
    rd(1'b1, 4'hC, 32'h0000_0067, "R6 full clear");
    wr(1'b1, 4'hC, 32'h0000_E06F);
    rd(1'b1, 4'hC, 32'h0000_0067, "R6 software cannot set");
    // R7 fault same cycle as clearing write
    acc(1'b1, 1'b1, 4'hC, 32'h0000_0067, 1'b1, 3'b001);
    rd(1'b1, 4'hC, 32'h0000_206F, "R7 fault wins over write");

    repeat (3) @(negedge clk_i);
    chk("R2 all reads returned", exp_q.size(), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule